// File: doc/BRIEF.md
# Vectored Exception Dispatcher

This block handles exception entry and return for a processor that dispatches through a vector table. Six request lines are ranked by a fixed priority. The two highest sources cannot be masked. The two synchronous sources are always taken. The external and timer sources are taken only while the enable bit of the machine-state register is set. In each cycle the dispatcher looks at the pending lines and picks the highest eligible one. It then forms the handler address by placing the source's vector number into a table of 256-byte slots. One bit of machine state chooses whether that table sits at address zero or at a high base.

When a request is accepted, the dispatcher saves the current PC into a first save register. It saves the restorable machine-state bits, plus a code naming the source, into a second save register. It then clears the enable and user-mode bits. A return command does the reverse: it copies the restorable bits back from the second save register and redirects fetch to the address held in the first save register, with its two low bits cleared. Handlers reach all three registers through a move-to write port and a move-from read port. This lets them store the save registers before they set the enable bit again. The PC, the request lines and the commands all come from ports. Fetch and execution live outside this block.

Top module: `exc_dispatch`

## Requirements
- R1: After reset, machine state reads 0x00000040, both save registers read 0, and `take` and `redirect` are low while no request or return is present.
- R2: Request bit i has rank i, and bit 0 is the highest. When any eligible request is present, `take` is high, `take_src` equals the index of the lowest-numbered eligible bit, and exactly one source is accepted that cycle. Lines that are still pending are taken in a later cycle once the higher ones drop.
- R3: Request bits 0 to 3 are eligible whatever the machine state holds. Bits 4 and 5 are eligible only while machine-state bit 15 (enable) is 1.
- R4: On acceptance, `redirect` is high and `redirect_pc` = base + vector × 0x100. The base is 0x00000000 when machine-state bit 6 is 0 and 0xFFF00000 when it is 1. The vectors for sources 0 to 5 are 1, 2, 6, 7, 5 and 9.
- R5: On the clock edge of an acceptance, save register 0 loads `pc_in`. Save register 1 loads (machine state AND 0x0000FF73) OR ((`take_src`+1) << 27).
- R6: On the same edge, machine-state bits 15 (enable) and 14 (user mode) are cleared. All other machine-state bits keep their value.
- R7: When `rfi` is high and nothing is accepted, `redirect` is high and `redirect_pc` = save register 0 with bits 1:0 forced to 0. On that edge, the machine-state bits selected by 0x0000FF73 are copied from save register 1 and the other bits are kept. Both save registers keep their value.
- R8: If a request is accepted in the same cycle as `rfi`, the return is ignored. The redirect goes to the handler, and machine state changes only as R6 says.
- R9: With `mt_en` high, `mt_data` is written at the clock edge into the register named by `mt_sel`: 0 is machine state, 1 is save register 0, 2 is save register 1, and 3 writes nothing. `mf_data` shows the register named by `mf_sel` in the same encoding, and reads 0 for code 3. An acceptance or a return in the same cycle overrides the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_in | input | 32 | PC of the instruction being interrupted |
| req | input | 6 | Exception request lines, bit 0 highest priority |
| rfi | input | 1 | Return-from-interrupt command |
| mt_en | input | 1 | Move-to write enable |
| mt_sel | input | 2 | Move-to register select |
| mt_data | input | 32 | Move-to write data |
| mf_sel | input | 2 | Move-from register select |
| mf_data | output | 32 | Move-from read data |
| take | output | 1 | A request is accepted this cycle |
| take_src | output | 3 | Index of the accepted source |
| take_vec | output | 5 | Vector number of the accepted source |
| redirect | output | 1 | Fetch must go to `redirect_pc` |
| redirect_pc | output | 32 | Handler address or return address |

## Verification
Acceptance and the handler address are combinational, so an error in the selector or in the address path shows up on `take`, `take_src` and `redirect_pc` in the very cycle the request is driven. An error in the saved PC, in the save-register image or in the enable and user-mode bits becomes visible one edge later through the move-from port. The next acceptance then also shows it, because a stale enable bit lets a masked source through, and a stale table-select bit moves every handler address. A wrong restore mask only shows after a return, when machine state is read back or when the next external request is wrongly taken or wrongly refused.

// File: rtl/exc_pkg.sv
package exc_pkg;

   // Machine-state bit positions (LSB = 0 numbering)
   localparam int unsigned MST_EE_POS = 15;   // external enable
   localparam int unsigned MST_PR_POS = 14;   // user mode when set
   localparam int unsigned MST_IP_POS = 6;    // high table base when set

   // Bits carried across entry/return in save register 1
   localparam logic [31:0] MST_RESTORE_MASK = 32'h0000_FF73;

   // Cause code field in save register 1
   localparam int unsigned INFO_LSB = 27;
   localparam int unsigned INFO_W   = 4;

   // Register select encoding for move-to / move-from
   typedef enum logic [1:0] {
      SEL_MST   = 2'd0,
      SEL_SAVE0 = 2'd1,
      SEL_SAVE1 = 2'd2,
      SEL_NONE  = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel #(
   parameter int unsigned      NSRC     = 6,
   parameter int unsigned      IDX_W    = 3,
   parameter logic [NSRC-1:0]  MASKABLE = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  req,
   input  logic             ee,
   output logic [NSRC-1:0]  grant,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   if ((1 << IDX_W) < NSRC) begin : g_bad_idx
      $error("exc_prio_sel: IDX_W too narrow for NSRC");
   end

   logic [NSRC-1:0] elig;

   for (genvar i = 0; i < NSRC; i++) begin : g_elig
      if (MASKABLE[i]) begin : g_masked
         assign elig[i] = req[i] & ee;
      end else begin : g_always
         assign elig[i] = req[i];
      end
   end

   // Lowest index wins: scan from the top so the last hit is the winner
   always_comb begin
      grant = '0;
      any   = 1'b0;
      idx   = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (elig[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            any      = 1'b1;
            idx      = IDX_W'(i);
         end
      end
   end

   a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   a_r2_grant_has_req: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req) == '0);

   a_r2_no_higher_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> ((req & (grant - 1'b1) & (ee ? {NSRC{1'b1}} : ~MASKABLE)) == '0));

   a_r3_masked_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      !ee |-> ((grant & MASKABLE) == '0));

endmodule

// File: rtl/exc_vec_addr.sv
module exc_vec_addr #(
   parameter int unsigned               XLEN      = 32,
   parameter int unsigned               NSRC      = 6,
   parameter int unsigned               IDX_W     = 3,
   parameter int unsigned               VEC_BITS  = 5,
   parameter int unsigned               VEC_SHIFT = 8,
   parameter logic [NSRC*VEC_BITS-1:0]  VEC_MAP   = '0,
   parameter logic [XLEN-1:0]           LO_BASE   = '0,
   parameter logic [XLEN-1:0]           HI_BASE   = '0
) (
   input  logic [IDX_W-1:0]    idx,
   input  logic                hi_sel,
   output logic [VEC_BITS-1:0] vec,
   output logic [XLEN-1:0]     addr
);

   localparam int unsigned     SPAN_W    = VEC_SHIFT + VEC_BITS;
   localparam logic [XLEN-1:0] SPAN_MASK = XLEN'((64'd1 << SPAN_W) - 64'd1);
   localparam bit              CAN_OR    = ((LO_BASE & SPAN_MASK) == '0) &&
                                           ((HI_BASE & SPAN_MASK) == '0);

   if (SPAN_W > XLEN) begin : g_bad_span
      $error("exc_vec_addr: vector table wider than the address");
   end

   logic [XLEN-1:0] base;
   logic [XLEN-1:0] offset;

   always_comb begin
      vec = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (idx == IDX_W'(i)) vec = VEC_MAP[i*VEC_BITS +: VEC_BITS];
      end
   end

   assign base   = hi_sel ? HI_BASE : LO_BASE;
   assign offset = XLEN'(vec) << VEC_SHIFT;

   // Aligned bases need no carry chain; otherwise fall back to an adder
   if (CAN_OR) begin : g_or_base
      assign addr = base | offset;
   end else begin : g_add_base
      assign addr = base + offset;
   end

endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs #(
   parameter int unsigned     XLEN      = 32,
   parameter int unsigned     IDX_W     = 3,
   parameter logic [XLEN-1:0] MST_RESET = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [IDX_W-1:0] take_idx,
   input  logic [XLEN-1:0]  pc_in,
   input  logic             rfi,
   input  logic             mt_en,
   input  logic [1:0]       mt_sel,
   input  logic [XLEN-1:0]  mt_data,
   output logic [XLEN-1:0]  mst,
   output logic [XLEN-1:0]  save0,
   output logic [XLEN-1:0]  save1
);
   import exc_pkg::*;

   localparam logic [XLEN-1:0] KEEP_MASK  = XLEN'(MST_RESTORE_MASK);
   localparam logic [XLEN-1:0] CLEAR_MASK = ~((XLEN'(1) << MST_EE_POS) |
                                              (XLEN'(1) << MST_PR_POS));

   if (INFO_LSB + INFO_W > XLEN) begin : g_bad_info
      $error("exc_state_regs: cause field outside save register");
   end
   if ((1 << INFO_W) <= (1 << IDX_W) - 1) begin : g_bad_info_w
      $error("exc_state_regs: cause field too narrow");
   end

   logic [INFO_W-1:0] info_code;
   logic [XLEN-1:0]   entry_image;

   assign info_code   = INFO_W'(take_idx) + INFO_W'(1);
   assign entry_image = (mst & KEEP_MASK) | (XLEN'(info_code) << INFO_LSB);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mst   <= MST_RESET;
         save0 <= '0;
         save1 <= '0;
      end else if (take) begin
         save0 <= pc_in;
         save1 <= entry_image;
         mst   <= mst & CLEAR_MASK;
      end else if (rfi) begin
         mst   <= (mst & ~KEEP_MASK) | (save1 & KEEP_MASK);
      end else if (mt_en) begin
         case (reg_sel_e'(mt_sel))
            SEL_MST:   mst   <= mt_data;
            SEL_SAVE0: save0 <= mt_data;
            SEL_SAVE1: save1 <= mt_data;
            default:   ;
         endcase
      end
   end

   a_r6_entry_clears: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (!mst[MST_EE_POS] && !mst[MST_PR_POS]));

   a_r5_save_pc: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (save0 == $past(pc_in)));

   a_r7_restore: assert property (@(posedge clk) disable iff (!rst_n)
      (rfi && !take) |=> (((mst & KEEP_MASK) == ($past(save1) & KEEP_MASK)) &&
                          $stable(save0) && $stable(save1)));

   a_r8_take_beats_rfi: assert property (@(posedge clk) disable iff (!rst_n)
      (take && rfi) |=> !mst[MST_EE_POS]);

   a_r9_write_save0: assert property (@(posedge clk) disable iff (!rst_n)
      (mt_en && !take && !rfi && mt_sel == 2'd1) |=> (save0 == $past(mt_data)));

endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch #(
   parameter int unsigned                 XLEN      = 32,
   parameter int unsigned                 NSRC      = 6,
   parameter int unsigned                 VEC_BITS  = 5,
   parameter int unsigned                 VEC_SHIFT = 8,
   parameter logic [NSRC-1:0]             MASKABLE  = 6'b110000,
   parameter logic [NSRC*VEC_BITS-1:0]    VEC_MAP   = {5'd9, 5'd5, 5'd7, 5'd6, 5'd2, 5'd1},
   parameter logic [XLEN-1:0]             LO_BASE   = 32'h0000_0000,
   parameter logic [XLEN-1:0]             HI_BASE   = 32'hFFF0_0000,
   parameter logic [XLEN-1:0]             MST_RESET = 32'h0000_0040
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [XLEN-1:0]           pc_in,
   input  logic [NSRC-1:0]           req,
   input  logic                      rfi,
   input  logic                      mt_en,
   input  logic [1:0]                mt_sel,
   input  logic [XLEN-1:0]           mt_data,
   input  logic [1:0]                mf_sel,
   output logic [XLEN-1:0]           mf_data,
   output logic                      take,
   output logic [$clog2(NSRC)-1:0]   take_src,
   output logic [VEC_BITS-1:0]       take_vec,
   output logic                      redirect,
   output logic [XLEN-1:0]           redirect_pc
);
   import exc_pkg::*;

   localparam int unsigned IDX_W = $clog2(NSRC);

   if (XLEN != 32) begin : g_bad_xlen
      $error("exc_dispatch: machine-state layout assumes 32 bits");
   end
   if (NSRC < 2) begin : g_bad_nsrc
      $error("exc_dispatch: at least two sources needed");
   end

   logic [NSRC-1:0] grant;
   logic [XLEN-1:0] mst;
   logic [XLEN-1:0] save0;
   logic [XLEN-1:0] save1;
   logic [XLEN-1:0] handler_pc;

   exc_prio_sel #(
      .NSRC     (NSRC),
      .IDX_W    (IDX_W),
      .MASKABLE (MASKABLE)
   ) u_sel (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .ee    (mst[MST_EE_POS]),
      .grant (grant),
      .any   (take),
      .idx   (take_src)
   );

   exc_vec_addr #(
      .XLEN      (XLEN),
      .NSRC      (NSRC),
      .IDX_W     (IDX_W),
      .VEC_BITS  (VEC_BITS),
      .VEC_SHIFT (VEC_SHIFT),
      .VEC_MAP   (VEC_MAP),
      .LO_BASE   (LO_BASE),
      .HI_BASE   (HI_BASE)
   ) u_vec (
      .idx    (take_src),
      .hi_sel (mst[MST_IP_POS]),
      .vec    (take_vec),
      .addr   (handler_pc)
   );

   exc_state_regs #(
      .XLEN      (XLEN),
      .IDX_W     (IDX_W),
      .MST_RESET (MST_RESET)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .take_idx (take_src),
      .pc_in    (pc_in),
      .rfi      (rfi),
      .mt_en    (mt_en),
      .mt_sel   (mt_sel),
      .mt_data  (mt_data),
      .mst      (mst),
      .save0    (save0),
      .save1    (save1)
   );

   assign redirect    = take | rfi;
   assign redirect_pc = take ? handler_pc : {save0[XLEN-1:2], 2'b00};

   always_comb begin
      case (reg_sel_e'(mf_sel))
         SEL_MST:   mf_data = mst;
         SEL_SAVE0: mf_data = save0;
         SEL_SAVE1: mf_data = save1;
         default:   mf_data = '0;
      endcase
   end

   a_r2_grant_matches_src: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (grant == (NSRC'(1) << take_src)));

   a_r7_return_target: assert property (@(posedge clk) disable iff (!rst_n)
      (rfi && !take) |-> (redirect && redirect_pc[1:0] == 2'b00));

endmodule

// File: tb/sim_exc_dispatch.sv
`timescale 1ns/1ps
module sim_exc_dispatch;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pc_in = '0;
   logic [5:0]  req = '0;
   logic        rfi = 1'b0;
   logic        mt_en = 1'b0;
   logic [1:0]  mt_sel = '0;
   logic [31:0] mt_data = '0;
   logic [1:0]  mf_sel = '0;
   logic [31:0] mf_data;
   logic        take;
   logic [2:0]  take_src;
   logic [4:0]  take_vec;
   logic        redirect;
   logic [31:0] redirect_pc;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   exc_dispatch u0 (
      .clk(clk), .rst_n(rst_n), .pc_in(pc_in), .req(req), .rfi(rfi),
      .mt_en(mt_en), .mt_sel(mt_sel), .mt_data(mt_data), .mf_sel(mf_sel),
      .mf_data(mf_data), .take(take), .take_src(take_src), .take_vec(take_vec),
      .redirect(redirect), .redirect_pc(redirect_pc)
   );

   function automatic logic [31:0] vec_of(int s);
      case (s)
         0: return 1;  1: return 2;  2: return 6;
         3: return 7;  4: return 5;  default: return 9;
      endcase
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] sel, logic [31:0] d);
      @(negedge clk);
      mt_en = 1'b1; mt_sel = sel; mt_data = d;
      @(posedge clk); #1;
      mt_en = 1'b0;
   endtask

   task automatic rd(logic [1:0] sel, output logic [31:0] v);
      mf_sel = sel;
      #0.2;
      v = mf_data;
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v, mst_val, pc, exp_pc;
      int src;

      // R1 reset state
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      rd(2'd0, v); chk("R1 mst", v, 32'h0000_0040);
      rd(2'd1, v); chk("R1 save0", v, 32'h0);
      rd(2'd2, v); chk("R1 save1", v, 32'h0);
      rd(2'd3, v); chk("R9 sel3 read", v, 32'h0);
      chk("R1 take", {31'd0, take}, 32'd0);
      chk("R1 redirect", {31'd0, redirect}, 32'd0);

      // R2 R3 R4 R5 R6 sweep over table select, enable and all request patterns
      for (int ip = 0; ip < 2; ip++) begin
         for (int ee = 0; ee < 2; ee++) begin
            for (int r = 0; r < 64; r++) begin
               mst_val = 32'hA5A5_4031 | (32'(ee) << 15) | (32'(ip) << 6);
               wr(2'd0, mst_val);
               wr(2'd1, 32'h0BAD_F00D);
               wr(2'd2, 32'h1234_5678);
               pc = 32'h4000_0000 + (32'(r) << 4) + 32'(ip * 2 + ee);
               src = -1;
               for (int i = 5; i >= 0; i--)
                  if (r[i] && (i < 4 || ee == 1)) src = i;
               @(negedge clk);
               req = 6'(r); pc_in = pc; #1;
               chk("R2/R3 take", {31'd0, take}, (src >= 0) ? 32'd1 : 32'd0);
               if (src >= 0) begin
                  chk("R2 take_src", {29'd0, take_src}, 32'(src));
                  exp_pc = (ip == 1 ? 32'hFFF0_0000 : 32'h0) + vec_of(src) * 32'h100;
                  chk("R4 redirect", {31'd0, redirect}, 32'd1);
                  chk("R4 handler", redirect_pc, exp_pc);
               end
               @(posedge clk); #1;
               req = '0;
               rd(2'd0, v);
               chk("R6 mst", v, (src >= 0) ? (mst_val & ~32'h0000_C000) : mst_val);
               rd(2'd1, v);
               chk("R5 save0", v, (src >= 0) ? pc : 32'h0BAD_F00D);
               rd(2'd2, v);
               chk("R5 save1", v, (src >= 0) ?
                   ((mst_val & 32'h0000_FF73) | (32'(src + 1) << 27)) : 32'h1234_5678);
            end
         end
      end

      // R7 return restores masked bits, case 1
      wr(2'd0, 32'h0);
      wr(2'd2, 32'hFFFF_FFFF);
      wr(2'd1, 32'h1234_5677);
      @(negedge clk); rfi = 1'b1; #1;
      chk("R7 take", {31'd0, take}, 32'd0);
      chk("R7 redirect", {31'd0, redirect}, 32'd1);
      chk("R7 return pc", redirect_pc, 32'h1234_5674);
      @(posedge clk); #1; rfi = 1'b0;
      rd(2'd0, v); chk("R7 mst set", v, 32'h0000_FF73);
      rd(2'd1, v); chk("R7 save0 kept", v, 32'h1234_5677);
      rd(2'd2, v); chk("R7 save1 kept", v, 32'hFFFF_FFFF);

      // R7 case 2: restore clears masked bits, keeps the rest
      wr(2'd0, 32'hFFFF_FFFF);
      wr(2'd2, 32'h0);
      @(negedge clk); rfi = 1'b1;
      @(posedge clk); #1; rfi = 1'b0;
      rd(2'd0, v); chk("R7 mst cleared", v, 32'hFFFF_008C);

      // R8 acceptance beats return
      wr(2'd0, 32'h0000_8040);
      wr(2'd2, 32'hFFFF_FFFF);
      @(negedge clk); rfi = 1'b1; req = 6'b000100; pc_in = 32'h2222_0008; #1;
      chk("R8 handler", redirect_pc, 32'hFFF0_0600);
      @(posedge clk); #1; rfi = 1'b0; req = '0;
      rd(2'd0, v); chk("R8 mst", v, 32'h0000_0040);
      rd(2'd2, v); chk("R8 save1", v, 32'h1800_8040);

      // R2 pending lower line taken once higher drops
      wr(2'd0, 32'h0000_8000);
      @(negedge clk); req = 6'b010010; #1;
      chk("R2 higher first", {29'd0, take_src}, 32'd1);
      @(posedge clk); #1; req = 6'b010000;
      rd(2'd0, v); chk("R3 ee cleared", v, 32'h0);
      #1; chk("R3 masked pending", {31'd0, take}, 32'd0);
      wr(2'd0, 32'h0000_8000);
      @(negedge clk); #1;
      chk("R2 pending taken", {29'd0, take_src}, 32'd4);
      chk("R4 ext handler", redirect_pc, 32'h0000_0500);
      @(posedge clk); #1; req = '0;

      // R9 move-to overridden by acceptance
      @(negedge clk);
      mt_en = 1'b1; mt_sel = 2'd1; mt_data = 32'hDEAD_BEEF;
      req = 6'b000001; pc_in = 32'h0000_0ABC;
      @(posedge clk); #1; mt_en = 1'b0; req = '0;
      rd(2'd1, v); chk("R9 write overridden", v, 32'h0000_0ABC);

      // R9 select 3 writes nothing
      wr(2'd0, 32'h1111_2222);
      wr(2'd1, 32'h3333_4444);
      wr(2'd2, 32'h5555_6666);
      wr(2'd3, 32'hFFFF_FFFF);
      rd(2'd0, v); chk("R9 sel3 mst", v, 32'h1111_2222);
      rd(2'd1, v); chk("R9 sel3 save0", v, 32'h3333_4444);
      rd(2'd2, v); chk("R9 sel3 save1", v, 32'h5555_6666);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule